// File: doc/BRIEF.md
# External Sync Slave Lock

This block keeps a video time base in phase with sync supplied from outside when the device runs as a timing slave. It keeps a pixel counter within each line and a line counter within each field, plus a field flag, and moves them onto the reference whenever an active sync edge arrives. Three discrete sync pins (frame, vertical, horizontal) are accepted. Each pin has its own polarity bit and its own two-flop synchronizer ahead of edge detection.

Phase can also be taken from the frame sync pin alone. Two separate enable bits decide whether the horizontal phase, the vertical phase, or both come from the frame sync edge. A pin whose phase is derived this way is ignored as an input, and a per-pin flag tells the pad logic that the pin may be driven as an output. As a second reference source, the block accepts timing-reference markers that an upstream decoder has already extracted from an 8-bit BT.656 stream. Frame sync is only needed for interlaced input, so a progressive source may leave it idle.

The field length is fixed to one of two line counts, one for 50 Hz and one for 60 Hz systems. The line length is programmed. For each counter, a lock flag reports whether consecutive references land at the same counter position.

Top module: `ext_sync_lock`

## Requirements
- R1: Each of fs_i, vs_i and hs_i has a polarity bit. A value of 0 makes the rising edge the active edge; 1 makes the falling edge active. The opposite edge has no effect.
- R2: An active hs_i edge sets pix_cnt_o to 0. The count reads 0 after the third rising clock edge that follows the pin change: two synchronizer flops, then the counter register.
- R3: pix_cnt_o counts up by one per clock from 0 to line_len_i-1 and then wraps to 0. line_cnt_o advances by one on each wrap and on each horizontal reference.
- R4: An active vs_i edge sets line_cnt_o to 0 and toggles field_o, with the same latency as R2.
- R5: Without a vertical reference, line_cnt_o wraps to 0 after 263 lines when rate_60_i is 1 and after 313 lines when it is 0. Each wrap toggles field_o.
- R6: In pin mode an active fs_i edge clears field_o to 0. Unless an enable bit selects it, fs_i has no effect on either counter.
- R7: With h_from_fs_i at 1, the fs_i edge zeroes pix_cnt_o and hs_i is ignored. With v_from_fs_i at 1, the fs_i edge zeroes line_cnt_o and vs_i is ignored.
- R8: hs_out_en_o equals h_from_fs_i AND NOT src_656_i. vs_out_en_o equals v_from_fs_i AND NOT src_656_i.
- R9: With src_656_i at 1 all three pins are ignored. A marker (trs_stb_i=1) with trs_h_i=1 (end of active video) zeroes pix_cnt_o on the next clock and loads field_o from trs_f_i. If the same marker has trs_v_i=1 while the previous such marker had trs_v_i=0, it also zeroes line_cnt_o.
- R10: h_lock_o is set at a horizontal reference when the pixel position captured at that reference equals the position captured at the previous one, and cleared when they differ. v_lock_o does the same with line positions. Both flags change only at their own references.
- R11: While rst_ni is low, pix_cnt_o, line_cnt_o, field_o, h_lock_o and v_lock_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_i | input | 1 | Frame sync pin |
| vs_i | input | 1 | Vertical sync pin |
| hs_i | input | 1 | Horizontal sync pin |
| fs_pol_i | input | 1 | Frame sync polarity, 1 = active low |
| vs_pol_i | input | 1 | Vertical sync polarity, 1 = active low |
| hs_pol_i | input | 1 | Horizontal sync polarity, 1 = active low |
| h_from_fs_i | input | 1 | Take horizontal phase from frame sync |
| v_from_fs_i | input | 1 | Take vertical phase from frame sync |
| src_656_i | input | 1 | Use decoded stream markers instead of pins |
| trs_stb_i | input | 1 | Decoded marker valid |
| trs_f_i | input | 1 | Marker field bit |
| trs_v_i | input | 1 | Marker vertical blanking bit |
| trs_h_i | input | 1 | Marker end-of-active bit |
| line_len_i | input | PIX_W | Pixels per line |
| rate_60_i | input | 1 | 1 = 60 Hz field length, 0 = 50 Hz |
| pix_cnt_o | output | PIX_W | Pixel position in line |
| line_cnt_o | output | LINE_W | Line position in field |
| field_o | output | 1 | Field flag |
| h_lock_o | output | 1 | Horizontal references consistent |
| v_lock_o | output | 1 | Vertical references consistent |
| hs_out_en_o | output | 1 | Horizontal pin free for output |
| vs_out_en_o | output | 1 | Vertical pin free for output |

## Verification
A stimulus table drives horizontal references at repeated, changed, and repeated-again spacings. This separates a lock that tracks equal capture positions from one that simply follows any reference. Pulses on pins in both polarities show whether only the programmed edge acts, and whether that edge shows up exactly three clocks later. Pulses on pins whose phase is taken from frame sync, or sent while stream markers are selected, must leave the counters on their free-running course. That course is predicted from the count sampled just before the pulse. Long free runs at a short line length cover both field lengths and the field toggle at each wrap.

// File: rtl/ext_sync_lock_pkg.sv
package ext_sync_lock_pkg;
  localparam int N_PINS = 3;
  localparam int IDX_HS = 0;
  localparam int IDX_VS = 1;
  localparam int IDX_FS = 2;

  typedef struct packed {
    logic h;        // zero pixel counter
    logic v;        // zero line counter
    logic fld_ld;   // load field flag
    logic fld_val;
    logic fld_tog;  // toggle field flag
  } ref_t;
endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  output logic edge_o
);
  logic [STAGES-1:0] sh_q;
  logic              act_q;
  logic              act;

  assign act    = sh_q[STAGES-1] ^ pol_i;
  assign edge_o = act & ~act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      act_q <= 1'b1;  // no spurious edge out of reset
    end else begin
      sh_q  <= {sh_q[STAGES-2:0], pin_i};
      act_q <= act;
    end
  end
endmodule

// File: rtl/ref_select.sv
module ref_select
  import ext_sync_lock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] edge_i,
  input  logic              src_656_i,
  input  logic              h_from_fs_i,
  input  logic              v_from_fs_i,
  input  logic              trs_stb_i,
  input  logic              trs_f_i,
  input  logic              trs_v_i,
  input  logic              trs_h_i,
  output ref_t              ref_o,
  output logic              hs_out_en_o,
  output logic              vs_out_en_o
);
  logic eav;
  logic v_prev_q;

  assign eav = trs_stb_i & trs_h_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  v_prev_q <= 1'b0;
    else if (eav) v_prev_q <= trs_v_i;
  end

  always_comb begin
    ref_o = '0;
    if (src_656_i) begin
      ref_o.h       = eav;
      ref_o.v       = eav & trs_v_i & ~v_prev_q;
      ref_o.fld_ld  = eav;
      ref_o.fld_val = trs_f_i;
    end else begin
      ref_o.h       = h_from_fs_i ? edge_i[IDX_FS] : edge_i[IDX_HS];
      ref_o.v       = v_from_fs_i ? edge_i[IDX_FS] : edge_i[IDX_VS];
      ref_o.fld_ld  = edge_i[IDX_FS];
      ref_o.fld_val = 1'b0;
      ref_o.fld_tog = ~v_from_fs_i & edge_i[IDX_VS];
    end
  end

  assign hs_out_en_o = h_from_fs_i & ~src_656_i;
  assign vs_out_en_o = v_from_fs_i & ~src_656_i;
endmodule

// File: rtl/lock_counter.sv
module lock_counter #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic         zero_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         lock_o
);
  logic [W-1:0] cap_q;
  logic         cap_vld_q;
  logic         at_lim;

  assign at_lim = cnt_o >= limit_i;
  assign wrap_o = adv_i & at_lim & ~zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '0;
      cap_q     <= '0;
      cap_vld_q <= 1'b0;
      lock_o    <= 1'b0;
    end else if (zero_i) begin
      cnt_o     <= '0;
      cap_q     <= cnt_o;
      cap_vld_q <= 1'b1;
      lock_o    <= cap_vld_q && (cnt_o == cap_q);
    end else if (adv_i) begin
      cnt_o <= at_lim ? '0 : cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/ext_sync_lock.sv
module ext_sync_lock
  import ext_sync_lock_pkg::*;
#(
  parameter int PIX_W          = 12,
  parameter int LINE_W         = 10,
  parameter int FIELD_LINES_50 = 313,
  parameter int FIELD_LINES_60 = 263,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_i,
  input  logic              vs_i,
  input  logic              hs_i,
  input  logic              fs_pol_i,
  input  logic              vs_pol_i,
  input  logic              hs_pol_i,
  input  logic              h_from_fs_i,
  input  logic              v_from_fs_i,
  input  logic              src_656_i,
  input  logic              trs_stb_i,
  input  logic              trs_f_i,
  input  logic              trs_v_i,
  input  logic              trs_h_i,
  input  logic [PIX_W-1:0]  line_len_i,
  input  logic              rate_60_i,
  output logic [PIX_W-1:0]  pix_cnt_o,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic              field_o,
  output logic              h_lock_o,
  output logic              v_lock_o,
  output logic              hs_out_en_o,
  output logic              vs_out_en_o
);
  localparam logic [LINE_W-1:0] LIM_50 = LINE_W'(FIELD_LINES_50 - 1);
  localparam logic [LINE_W-1:0] LIM_60 = LINE_W'(FIELD_LINES_60 - 1);

  logic [N_PINS-1:0] pin_vec, pol_vec, edge_vec;
  ref_t              ref_q;
  logic              pix_wrap, line_wrap;
  logic [PIX_W-1:0]  pix_lim;
  logic [LINE_W-1:0] line_lim;

  assign pin_vec = {fs_i, vs_i, hs_i};
  assign pol_vec = {fs_pol_i, vs_pol_i, hs_pol_i};

  for (genvar g = 0; g < N_PINS; g++) begin : g_det
    sync_edge_det #(.STAGES(SYNC_STAGES)) u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pin_vec[g]),
      .pol_i (pol_vec[g]),
      .edge_o(edge_vec[g])
    );
  end

  ref_select u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edge_i     (edge_vec),
    .src_656_i  (src_656_i),
    .h_from_fs_i(h_from_fs_i),
    .v_from_fs_i(v_from_fs_i),
    .trs_stb_i  (trs_stb_i),
    .trs_f_i    (trs_f_i),
    .trs_v_i    (trs_v_i),
    .trs_h_i    (trs_h_i),
    .ref_o      (ref_q),
    .hs_out_en_o(hs_out_en_o),
    .vs_out_en_o(vs_out_en_o)
  );

  assign pix_lim  = line_len_i - 1'b1;
  assign line_lim = rate_60_i ? LIM_60 : LIM_50;

  lock_counter #(.W(PIX_W)) u_pix (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (1'b1),
    .zero_i (ref_q.h),
    .limit_i(pix_lim),
    .cnt_o  (pix_cnt_o),
    .wrap_o (pix_wrap),
    .lock_o (h_lock_o)
  );

  lock_counter #(.W(LINE_W)) u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (pix_wrap | ref_q.h),
    .zero_i (ref_q.v),
    .limit_i(line_lim),
    .cnt_o  (line_cnt_o),
    .wrap_o (line_wrap),
    .lock_o (v_lock_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        field_o <= 1'b0;
    else if (ref_q.fld_ld)              field_o <= ref_q.fld_val;
    else if (ref_q.fld_tog | line_wrap) field_o <= ~field_o;
  end
endmodule

// File: rtl/ext_sync_lock_chk.sv
module ext_sync_lock_chk #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              src_656_i,
  input logic [PIX_W-1:0]  line_len_i,
  input logic [PIX_W-1:0]  pix_cnt_o,
  input logic [LINE_W-1:0] line_cnt_o,
  input logic              field_o,
  input logic              h_lock_o,
  input logic              v_lock_o,
  input logic              hs_out_en_o,
  input logic              vs_out_en_o,
  input logic              ref_h,
  input logic              ref_v,
  input logic              ref_fld_ld,
  input logic              ref_fld_tog
);
  logic [PIX_W:0] pix_nxt;
  assign pix_nxt = {1'b0, pix_cnt_o} + 1'b1;

  a_r2_pix_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_h |=> pix_cnt_o == '0);

  a_r4_line_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_v |=> line_cnt_o == '0);

  a_r3_pix_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_h && pix_nxt < {1'b0, line_len_i}) |=>
      pix_cnt_o == PIX_W'($past(pix_cnt_o) + 1'b1));

  a_r4_field_tog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_fld_tog && !ref_fld_ld) |=> field_o != $past(field_o));

  a_r6_field_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_fld_ld && !src_656_i) |=> !field_o);

  a_r10_hlock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_h |=> $stable(h_lock_o));

  a_r10_vlock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_v |=> $stable(v_lock_o));

  a_r8_out_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_out_en_o || vs_out_en_o) |-> !src_656_i);
endmodule

bind ext_sync_lock ext_sync_lock_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_656_i  (src_656_i),
  .line_len_i (line_len_i),
  .pix_cnt_o  (pix_cnt_o),
  .line_cnt_o (line_cnt_o),
  .field_o    (field_o),
  .h_lock_o   (h_lock_o),
  .v_lock_o   (v_lock_o),
  .hs_out_en_o(hs_out_en_o),
  .vs_out_en_o(vs_out_en_o),
  .ref_h      (ref_q.h),
  .ref_v      (ref_q.v),
  .ref_fld_ld (ref_q.fld_ld),
  .ref_fld_tog(ref_q.fld_tog)
);

// File: tb/ext_sync_lock_bench.sv
`timescale 1ns/1ps
module ext_sync_lock_bench;
  localparam int PIX_W  = 12;
  localparam int LINE_W = 10;
  localparam int NVEC   = 7;
  // {gap between horizontal references, expected h_lock}
  localparam logic [8:0] VEC [NVEC] = '{
    {8'd30, 1'b0}, {8'd30, 1'b1}, {8'd30, 1'b1}, {8'd25, 1'b0},
    {8'd25, 1'b1}, {8'd40, 1'b0}, {8'd40, 1'b1}};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic fs_i = 0, vs_i = 0, hs_i = 0;
  logic fs_pol_i = 0, vs_pol_i = 0, hs_pol_i = 0;
  logic h_from_fs_i = 0, v_from_fs_i = 0, src_656_i = 0;
  logic trs_stb_i = 0, trs_f_i = 0, trs_v_i = 0, trs_h_i = 0;
  logic [PIX_W-1:0] line_len_i = 12'd64;
  logic rate_60_i = 1'b1;
  logic [PIX_W-1:0] pix_cnt_o;
  logic [LINE_W-1:0] line_cnt_o;
  logic field_o, h_lock_o, v_lock_o, hs_out_en_o, vs_out_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  ext_sync_lock #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_ext_sync_lock (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R11 pix", pix_cnt_o, 0);
    chk("R11 line", line_cnt_o, 0);
    chk("R11 field", field_o, 0);
    chk("R11 hlock", h_lock_o, 0);
    chk("R11 vlock", v_lock_o, 0);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk_i);
  endtask

  // called at a negedge; returns at the third negedge after the pin change
  task automatic pulse(input bit dh, input bit dv, input bit df);
    if (dh) hs_i = ~hs_pol_i;
    if (dv) vs_i = ~vs_pol_i;
    if (df) fs_i = ~fs_pol_i;
    repeat (3) @(negedge clk_i);
    if (dh) hs_i = hs_pol_i;
    if (dv) vs_i = vs_pol_i;
    if (df) fs_i = fs_pol_i;
  endtask

  task automatic marker(input bit f, input bit v);
    trs_stb_i = 1; trs_h_i = 1; trs_f_i = f; trs_v_i = v;
    @(negedge clk_i);
    trs_stb_i = 0; trs_h_i = 0;
  endtask

  initial begin
    int p0, l0, f0;
    @(negedge clk_i);
    do_reset();

    // R2 first reference
    pulse(1, 0, 0);
    chk("R2 pix zero", pix_cnt_o, 0);
    chk("R10 first ref no lock", h_lock_o, 0);

    // R10 table of spacings
    for (int i = 0; i < NVEC; i++) begin
      repeat (int'(VEC[i][8:1]) - 3) @(negedge clk_i);
      pulse(1, 0, 0);
      chk("R2 pix zero", pix_cnt_o, 0);
      chk("R10 h_lock", h_lock_o, int'(VEC[i][0]));
    end

    // R3 free run and wrap
    l0 = line_cnt_o;
    repeat (10) @(negedge clk_i);
    chk("R3 pix count", pix_cnt_o, 10);
    repeat (54) @(negedge clk_i);
    chk("R3 pix wrap", pix_cnt_o, 0);
    chk("R3 line adv", line_cnt_o, l0 + 1);

    // R4 vertical edge
    f0 = field_o;
    pulse(0, 1, 0);
    chk("R4 line zero", line_cnt_o, 0);
    chk("R4 field toggle", field_o, 1 - f0);
    if (!field_o) pulse(0, 1, 0);

    // R6 frame sync clears field only
    p0 = pix_cnt_o;
    pulse(0, 0, 1);
    chk("R6 field clear", field_o, 0);
    chk("R6 pix untouched", pix_cnt_o, (p0 + 3) % 64);

    // R7/R8 phase from frame sync
    h_from_fs_i = 1; v_from_fs_i = 1;
    @(negedge clk_i);
    chk("R8 hs_out_en", hs_out_en_o, 1);
    chk("R8 vs_out_en", vs_out_en_o, 1);
    p0 = pix_cnt_o; l0 = line_cnt_o;
    pulse(1, 1, 0);
    chk("R7 hs ignored", pix_cnt_o, (p0 + 3) % 64);
    chk("R7 vs ignored", line_cnt_o, l0 + ((p0 + 3) >= 64 ? 1 : 0));
    repeat (5) @(negedge clk_i);
    pulse(0, 0, 1);
    chk("R7 fs zeroes pix", pix_cnt_o, 0);
    chk("R7 fs zeroes line", line_cnt_o, 0);
    v_from_fs_i = 0;
    @(negedge clk_i);
    chk("R8 hs_out_en only", hs_out_en_o, 1);
    chk("R8 vs_out_en off", vs_out_en_o, 0);

    // R9 stream markers
    h_from_fs_i = 0; src_656_i = 1;
    @(negedge clk_i);
    chk("R8 out_en off in stream mode", hs_out_en_o | vs_out_en_o, 0);
    p0 = pix_cnt_o;
    pulse(1, 0, 0);
    chk("R9 pins ignored", pix_cnt_o, (p0 + 3) % 64);
    repeat (4) @(negedge clk_i);
    marker(1, 0);
    chk("R9 marker pix zero", pix_cnt_o, 0);
    chk("R9 field load", field_o, 1);
    repeat (5) @(negedge clk_i);
    marker(0, 1);
    chk("R9 v rise line zero", line_cnt_o, 0);
    chk("R9 field load 0", field_o, 0);
    src_656_i = 0;

    // R5 field length
    line_len_i = 12'd8;
    do_reset();
    pulse(1, 1, 0);
    chk("R5 start", line_cnt_o, 0);
    f0 = field_o;
    repeat (263 * 8 - 1) @(negedge clk_i);
    chk("R5 last line 60", line_cnt_o, 262);
    @(negedge clk_i);
    chk("R5 wrap 60", line_cnt_o, 0);
    chk("R5 field toggle 60", field_o, 1 - f0);
    rate_60_i = 0;
    repeat (313 * 8 - 1) @(negedge clk_i);
    chk("R5 last line 50", line_cnt_o, 312);
    @(negedge clk_i);
    chk("R5 wrap 50", line_cnt_o, 0);
    chk("R5 field toggle 50", field_o, f0);

    // R1 active-low polarity
    line_len_i = 12'd64; rate_60_i = 1;
    hs_pol_i = 1; vs_pol_i = 1; fs_pol_i = 1;
    hs_i = 1; vs_i = 1; fs_i = 1;
    do_reset();
    repeat (5) @(negedge clk_i);
    pulse(1, 0, 0);
    chk("R1 falling edge zeroes pix", pix_cnt_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R1 rising edge ignored", pix_cnt_o, 3);
    pulse(0, 1, 0);
    chk("R1 falling vs zeroes line", line_cnt_o, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule